// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small fully associative TLB that maps 32-bit virtual addresses to physical addresses. Each entry holds a tag word (virtual page, address-space ID, shared flag, valid flag) and a data word (physical page, page size, cache mode, supervisor protect, read/write/execute permissions, lock). Software loads an entry by presenting both words with a write strobe. The write goes either to an explicit index or to the slot chosen by a built-in round-robin victim pointer, which passes over locked entries.

Each lookup presents a virtual address, the current address-space ID, a supervisor flag, an address-space-mode bit and an access type. One clock later the block reports hit or miss, the translated address, a permission fault and a flag for more than one matching entry. ASID matching has two sharing levels. The shared flag removes the ASID compare for user accesses. The mode bit makes supervisor accesses match only entries whose ASID is zero. A shared entry with a non-zero ASID therefore serves all users but not the supervisor, and a shared entry with ASID zero serves everyone.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid and respValid is 0, so any lookup misses until an entry is written.
- R2: Tag word layout: bits 31:10 virtual page, bits 9:2 ASID, bit 1 shared, bit 0 valid. An entry with bit 0 clear never hits.
- R3: For a user access (isSuper=0), an entry hits on its ASID only if the ASID equals curAsid, or if the shared bit is set, in which case the ASID is ignored.
- R4: For a supervisor access with asidMode=1, an entry matches on ASID only when its ASID is 0x00, whatever its shared bit.
- R5: For a supervisor access with asidMode=0, ASID matching follows the user rule of R3.
- R6: Data word bits 9:8 select the page size: 0 = 1 KB (VA 31:10 compared), 1 = 4 KB (31:12), 2 = 8 KB (31:13), 3 = 1 MB (31:20). respPa takes the compared bits from data bits 31:10 and the remaining low bits from the virtual address.
- R7: accType 0 = read (data bit 4), 1 = write (bit 3), 2 = execute (bit 2), 3 = reserved. A hit faults when the selected permission bit is clear, and always faults for accType 3.
- R8: A hit whose supervisor-protect bit (data bit 5) is set faults for user accesses and does not fault on that account for supervisor accesses.
- R9: On a miss, respHit, respFault and respMulti are 0 and respPa is 0. When more than one entry hits, respHit and respMulti are 1, and the lowest-numbered hitting entry supplies respPa and the fault.
- R10: respValid and the result appear exactly one clock after the reqValid cycle. A lookup in the same cycle as a write sees the entry's old contents.
- R11: A write with wrUseVictim=0 stores both words into entry wrIndex even when that entry's lock bit (data bit 1) is set, and does not move the victim pointer.
- R12: A write with wrUseVictim=1 goes to the first entry at or after the victim pointer, wrapping, whose lock bit is clear. The pointer then moves to the entry after it. When every entry is locked the write is dropped and the pointer holds. The pointer is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Entry write strobe |
| wrUseVictim | input | 1 | 1: write to victim-pointer slot, 0: write to wrIndex |
| wrIndex | input | IDX_W | Explicit entry index |
| wrTag | input | 32 | Tag word to store |
| wrData | input | 32 | Data word to store |
| reqValid | input | 1 | Lookup request strobe |
| reqVa | input | 32 | Virtual address to translate |
| curAsid | input | 8 | Current address-space ID |
| isSuper | input | 1 | Access is from supervisor mode |
| asidMode | input | 1 | Supervisor accesses match ASID zero only |
| accType | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| respValid | output | 1 | Lookup result valid |
| respHit | output | 1 | At least one entry hit |
| respPa | output | 32 | Translated physical address |
| respFault | output | 1 | Permission fault on the hit |
| respMulti | output | 1 | More than one entry hit |

## Verification
The bench builds the block with the default four entries. With so few entries the victim pointer wraps after a handful of writes, and making every entry locked takes only four indexed writes. Duplicate tags giving multiple hits also appear often under random stimulus, because the random virtual pages come from a small pool. All four page sizes and both settings of the mode bit are mixed across user and supervisor lookups. This brings the ASID-zero and non-zero shared cases within reach in a few hundred operations.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef struct packed {
    logic [21:0] vpn;
    logic [7:0]  asid;
    logic        shared;
    logic        valid;
  } tagWord_t;

  typedef struct packed {
    logic [21:0] ppn;
    logic [1:0]  size;
    logic [1:0]  cmode;
    logic        supProt;
    logic        canRd;
    logic        canWr;
    logic        canEx;
    logic        lock;
    logic        rsvd;
  } dataWord_t;

  localparam int MAX_IDX_W = 8;

  typedef struct packed {
    logic                 writeEn;
    logic [MAX_IDX_W-1:0] writeIdx;
    logic                 lookupEn;
  } ctrlStrobe_t;

  // vpn bits that take part in the compare for a given page size
  function automatic logic [21:0] pageMask(input logic [1:0] size);
    case (size)
      2'd0:    pageMask = 22'h3FFFFF;
      2'd1:    pageMask = 22'h3FFFFC;
      2'd2:    pageMask = 22'h3FFFF8;
      default: pageMask = 22'h3FFC00;
    endcase
  endfunction

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic                   wrUseVictim,
  input  logic [IDX_W-1:0]       wrIndex,
  input  logic                   reqValid,
  input  logic [NUM_ENTRIES-1:0] lockVec,
  output ctrlStrobe_t            strobe
);

  logic [IDX_W-1:0] victimPtr;
  logic [IDX_W-1:0] victimTarget;
  logic             victimFound;

  always_comb begin
    victimFound  = 1'b0;
    victimTarget = victimPtr;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      int cand;
      cand = (int'(victimPtr) + k) % NUM_ENTRIES;
      if (!victimFound && !lockVec[cand]) begin
        victimFound  = 1'b1;
        victimTarget = IDX_W'(cand);
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.writeEn  = wrEn && (!wrUseVictim || victimFound);
    strobe.writeIdx = MAX_IDX_W'(wrUseVictim ? victimTarget : wrIndex);
    strobe.lookupEn = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimPtr <= '0;
    end else if (wrEn && wrUseVictim && victimFound) begin
      if (int'(victimTarget) == NUM_ENTRIES - 1) victimPtr <= '0;
      else victimPtr <= victimTarget + 1'b1;
    end
  end

endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic [31:0]            wrTag,
  input  logic [31:0]            wrData,
  input  logic [31:0]            reqVa,
  input  logic [7:0]             curAsid,
  input  logic                   isSuper,
  input  logic                   asidMode,
  input  logic [1:0]             accType,
  output logic [NUM_ENTRIES-1:0] lockVec,
  output logic                   respValid,
  output logic                   respHit,
  output logic [31:0]            respPa,
  output logic                   respFault,
  output logic                   respMulti
);

  tagWord_t  tagArr  [NUM_ENTRIES];
  dataWord_t dataArr [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hitVec;
  logic [IDX_W-1:0] writeIdx;

  logic unusedStrobeBits;
  assign unusedStrobeBits = ^strobe.writeIdx[MAX_IDX_W-1:IDX_W];
  assign writeIdx = strobe.writeIdx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        tagArr[i]  <= '0;
        dataArr[i] <= '0;
      end
    end else if (strobe.writeEn) begin
      tagArr[writeIdx]  <= tagWord_t'(wrTag);
      dataArr[writeIdx] <= dataWord_t'(wrData);
    end
  end

  logic [21:0] vaPage;
  assign vaPage = reqVa[31:10];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gEntry
    logic [21:0] mask;
    logic        pageOk;
    logic        asidOk;
    assign mask    = pageMask(dataArr[g].size);
    assign pageOk  = ((vaPage ^ tagArr[g].vpn) & mask) == '0;
    assign asidOk  = (isSuper && asidMode) ? (tagArr[g].asid == 8'h00)
                   : (tagArr[g].shared || tagArr[g].asid == curAsid);
    assign hitVec[g]  = tagArr[g].valid && pageOk && asidOk;
    assign lockVec[g] = dataArr[g].lock;
  end

  logic        anyHit;
  logic        multiHit;
  dataWord_t   selData;
  logic [31:0] nextPa;
  logic        permOk;
  logic        nextFault;

  always_comb begin
    selData  = '0;
    anyHit   = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        selData = dataArr[i];
        anyHit  = 1'b1;
      end
    end
    multiHit = $countones(hitVec) > 1;
  end

  always_comb begin
    logic [21:0] m;
    m      = pageMask(selData.size);
    nextPa = anyHit ? {(selData.ppn & m) | (vaPage & ~m), reqVa[9:0]} : 32'h0;
    case (accType)
      2'd0:    permOk = selData.canRd;
      2'd1:    permOk = selData.canWr;
      2'd2:    permOk = selData.canEx;
      default: permOk = 1'b0;
    endcase
    nextFault = anyHit && (!permOk || (selData.supProt && !isSuper));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respPa    <= '0;
      respFault <= 1'b0;
      respMulti <= 1'b0;
    end else begin
      respValid <= strobe.lookupEn;
      if (strobe.lookupEn) begin
        respHit   <= anyHit;
        respPa    <= nextPa;
        respFault <= nextFault;
        respMulti <= multiHit;
      end
    end
  end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrUseVictim,
  input  logic [IDX_W-1:0] wrIndex,
  input  logic [31:0]      wrTag,
  input  logic [31:0]      wrData,
  input  logic             reqValid,
  input  logic [31:0]      reqVa,
  input  logic [7:0]       curAsid,
  input  logic             isSuper,
  input  logic             asidMode,
  input  logic [1:0]       accType,
  output logic             respValid,
  output logic             respHit,
  output logic [31:0]      respPa,
  output logic             respFault,
  output logic             respMulti
);

  ctrlStrobe_t            strobe;
  logic [NUM_ENTRIES-1:0] lockVec;

  tlb_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrUseVictim(wrUseVictim),
    .wrIndex(wrIndex), .reqValid(reqValid), .lockVec(lockVec), .strobe(strobe)
  );

  tlb_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrTag(wrTag), .wrData(wrData),
    .reqVa(reqVa), .curAsid(curAsid), .isSuper(isSuper), .asidMode(asidMode),
    .accType(accType), .lockVec(lockVec), .respValid(respValid),
    .respHit(respHit), .respPa(respPa), .respFault(respFault),
    .respMulti(respMulti)
  );

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] reqVa,
  input logic        respValid,
  input logic        respHit,
  input logic [31:0] respPa,
  input logic        respFault,
  input logic        respMulti
);

  AST_RESP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid); // R10

  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid); // R10

  AST_MISS_IS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (respPa == 32'h0 && !respFault && !respMulti)); // R9

  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFault) |-> respHit); // R7

  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respMulti) |-> respHit); // R9

  AST_OFFSET_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid ##1 respHit) |-> respPa[9:0] == $past(reqVa[9:0])); // R6

endmodule

bind asid_tlb tlb_checker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa),
  .respValid(respValid), .respHit(respHit), .respPa(respPa),
  .respFault(respFault), .respMulti(respMulti)
);

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, wrUseVictim = 0;
  logic [IW-1:0] wrIndex = '0;
  logic [31:0] wrTag = '0, wrData = '0, reqVa = '0;
  logic reqValid = 0, isSuper = 0, asidMode = 0;
  logic [7:0] curAsid = '0;
  logic [1:0] accType = '0;
  logic respValid, respHit, respFault, respMulti;
  logic [31:0] respPa;

  int checks = 0, fails = 0;
  logic [31:0] mTag [N];
  logic [31:0] mData [N];
  int mPtr = 0;

  always #4 clk = ~clk;

  asid_tlb #(.NUM_ENTRIES(N)) u_dut (.*);

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [21:0] maskOf(input logic [1:0] s);
    case (s)
      2'd0: return 22'h3FFFFF;
      2'd1: return 22'h3FFFFC;
      2'd2: return 22'h3FFFF8;
      default: return 22'h3FFC00;
    endcase
  endfunction

  function automatic logic entHit(input int i, input logic [31:0] va, input logic [7:0] asid,
                                  input logic sup, input logic md);
    logic [21:0] m;
    logic aOk;
    m = maskOf(mData[i][9:8]);
    if (sup && md) aOk = (mTag[i][9:2] == 8'h00);
    else aOk = mTag[i][1] || (mTag[i][9:2] == asid);
    return mTag[i][0] && aOk && (((va[31:10] ^ mTag[i][31:10]) & m) == 22'h0);
  endfunction

  task automatic doWrite(input logic victim, input int idx, input logic [31:0] t, input logic [31:0] d);
    int tgt;
    @(negedge clk);
    wrEn = 1; wrUseVictim = victim; wrIndex = IW'(idx); wrTag = t; wrData = d;
    @(negedge clk);
    wrEn = 0;
    if (!victim) begin
      mTag[idx] = t; mData[idx] = d;
    end else begin
      tgt = -1;
      for (int k = 0; k < N; k++)
        if (tgt < 0 && !mData[(mPtr + k) % N][1]) tgt = (mPtr + k) % N;
      if (tgt >= 0) begin
        mTag[tgt] = t; mData[tgt] = d; mPtr = (tgt + 1) % N;
      end
    end
  endtask

  task automatic doLookup(input string req, input logic [31:0] va, input logic [7:0] asid,
                          input logic sup, input logic md, input logic [1:0] at);
    int first, cnt;
    logic perm;
    logic [31:0] ePa;
    logic eFault;
    logic [21:0] m;
    first = -1; cnt = 0;
    for (int i = 0; i < N; i++)
      if (entHit(i, va, asid, sup, md)) begin
        cnt++;
        if (first < 0) first = i;
      end
    ePa = 0; eFault = 0;
    if (first >= 0) begin
      m = maskOf(mData[first][9:8]);
      ePa = {(mData[first][31:10] & m) | (va[31:10] & ~m), va[9:0]};
      perm = (at == 0) ? mData[first][4] : (at == 1) ? mData[first][3] :
             (at == 2) ? mData[first][2] : 1'b0;
      eFault = !perm || (mData[first][5] && !sup);
    end
    @(negedge clk);
    reqValid = 1; reqVa = va; curAsid = asid; isSuper = sup; asidMode = md; accType = at;
    @(negedge clk);
    reqValid = 0;
    chk(req, "respValid R10", 32'(respValid), 32'd1);
    chk(req, "respHit", 32'(respHit), 32'(first >= 0));
    chk(req, "respPa", respPa, ePa);
    chk(req, "respFault", 32'(respFault), 32'(eFault));
    chk(req, "respMulti", 32'(respMulti), 32'(cnt > 1));
  endtask

  function automatic logic [31:0] mkTag(input logic [31:0] va, input logic [7:0] asid, input logic sg, input logic v);
    return {va[31:10], asid, sg, v};
  endfunction

  // ppnBase, size, sp, r, w, x, lock
  function automatic logic [31:0] mkData(input logic [31:0] pa, input logic [1:0] sz, input logic sp,
                                         input logic r, input logic w, input logic x, input logic lk);
    return {pa[31:10], sz, 2'b00, sp, r, w, x, lk, 1'b0};
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin mTag[i] = 0; mData[i] = 0; end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1", "respValid after reset", 32'(respValid), 32'd0);
    doLookup("R1", 32'h0010_0123, 8'd0, 0, 0, 2'd0);
    doLookup("R1", 32'h0000_0000, 8'd0, 1, 1, 2'd0);
    @(negedge clk);
    chk("R10", "respValid idle", 32'(respValid), 32'd0);

    // victim round robin from pointer 0 with entries 0 and 2 locked
    doWrite(0, 0, mkTag(32'h7000_0000, 8'd1, 0, 1), mkData(32'hA000_0000, 0, 0, 1, 1, 1, 1));
    doWrite(0, 2, mkTag(32'h7100_0000, 8'd1, 0, 1), mkData(32'hA100_0000, 0, 0, 1, 1, 1, 1));
    doWrite(1, 0, mkTag(32'h7200_0000, 8'd1, 0, 1), mkData(32'hA200_0000, 0, 0, 1, 1, 1, 0));
    doWrite(1, 0, mkTag(32'h7300_0000, 8'd1, 0, 1), mkData(32'hA300_0000, 0, 0, 1, 1, 1, 0));
    doWrite(1, 0, mkTag(32'h7400_0000, 8'd1, 0, 1), mkData(32'hA400_0000, 0, 0, 1, 1, 1, 0));
    doLookup("R12", 32'h7000_0010, 8'd1, 0, 0, 2'd0);
    doLookup("R12", 32'h7100_0010, 8'd1, 0, 0, 2'd0);
    doLookup("R12", 32'h7200_0010, 8'd1, 0, 0, 2'd0);
    doLookup("R12", 32'h7300_0010, 8'd1, 0, 0, 2'd0);
    doLookup("R12", 32'h7400_0010, 8'd1, 0, 0, 2'd0);
    // all locked: victim write dropped
    doWrite(0, 1, mkTag(32'h7400_0000, 8'd1, 0, 1), mkData(32'hA400_0000, 0, 0, 1, 1, 1, 1));
    doWrite(0, 3, mkTag(32'h7300_0000, 8'd1, 0, 1), mkData(32'hA300_0000, 0, 0, 1, 1, 1, 1));
    doWrite(1, 0, mkTag(32'h7500_0000, 8'd1, 0, 1), mkData(32'hA500_0000, 0, 0, 1, 1, 1, 0));
    doLookup("R12", 32'h7500_0000, 8'd1, 0, 0, 2'd0);
    doLookup("R12", 32'h7400_0000, 8'd1, 0, 0, 2'd0);
    // indexed overwrite of locked entry
    doWrite(0, 0, mkTag(32'h0010_0000, 8'd5, 0, 1), mkData(32'h1234_5000, 0, 0, 1, 0, 1, 0));
    doLookup("R11", 32'h7000_0000, 8'd1, 0, 0, 2'd0);
    doLookup("R11", 32'h0010_0123, 8'd5, 0, 0, 2'd0);
    chk("R6", "1KB pa", respPa, 32'h1234_5123);
    doWrite(0, 1, 32'h0, 32'h0);
    doWrite(0, 2, 32'h0, 32'h0);
    doWrite(0, 3, 32'h0, 32'h0);

    doLookup("R3", 32'h0010_0123, 8'd6, 0, 0, 2'd0);
    doLookup("R7", 32'h0010_0123, 8'd5, 0, 0, 2'd1);
    chk("R7", "write fault", 32'(respFault), 32'd1);
    doLookup("R7", 32'h0010_0123, 8'd5, 0, 0, 2'd2);
    doLookup("R7", 32'h0010_0123, 8'd5, 0, 0, 2'd3);
    doWrite(0, 0, mkTag(32'h0010_0000, 8'd5, 1, 1), mkData(32'h1234_5000, 0, 0, 1, 0, 1, 0));
    doLookup("R3", 32'h0010_0123, 8'd6, 0, 0, 2'd0);
    chk("R3", "shared hit", 32'(respHit), 32'd1);
    doLookup("R4", 32'h0010_0123, 8'd5, 1, 1, 2'd0);
    chk("R4", "nonzero shared super miss", 32'(respHit), 32'd0);
    doLookup("R5", 32'h0010_0123, 8'd5, 1, 0, 2'd0);
    doLookup("R5", 32'h0010_0123, 8'd9, 1, 0, 2'd0);
    doWrite(0, 1, mkTag(32'h0020_0000, 8'd0, 1, 1), mkData(32'h5550_0000, 1, 0, 1, 1, 0, 0));
    doLookup("R4", 32'h0020_0ABC, 8'd7, 1, 1, 2'd1);
    chk("R4", "zero shared super hit", 32'(respHit), 32'd1);
    doLookup("R4", 32'h0020_0ABC, 8'd7, 0, 1, 2'd1);
    doWrite(0, 1, mkTag(32'h0020_0000, 8'd0, 0, 0), mkData(32'h5550_0000, 1, 0, 1, 1, 0, 0));
    doLookup("R2", 32'h0020_0ABC, 8'd0, 1, 1, 2'd0);
    doWrite(0, 2, mkTag(32'h4000_0000, 8'd3, 0, 1), mkData(32'h8A50_0000, 3, 1, 1, 1, 1, 0));
    doLookup("R6", 32'h400A_BCDE, 8'd3, 1, 0, 2'd0);
    chk("R6", "1MB pa", respPa, 32'h8A5A_BCDE);
    doLookup("R8", 32'h400A_BCDE, 8'd3, 0, 0, 2'd0);
    chk("R8", "user sp fault", 32'(respFault), 32'd1);
    doWrite(0, 3, mkTag(32'h4000_0000, 8'd3, 0, 1), mkData(32'h9000_0000, 2, 0, 0, 0, 0, 0));
    doLookup("R9", 32'h4000_1234, 8'd3, 1, 0, 2'd0);
    chk("R9", "multi", 32'(respMulti), 32'd1);

    for (int it = 0; it < 600; it++) begin
      logic [31:0] va;
      int pick;
      pick = $urandom % 4;
      va = {((pick == 0) ? 10'h001 : (pick == 1) ? 10'h100 : (pick == 2) ? 10'h2A0 : 10'h3FF),
            12'($urandom % 8) << 9 | 12'($urandom % 4), 10'($urandom)};
      if ($urandom % 3 == 0)
        doWrite(1'($urandom % 2), $urandom % N,
                mkTag(va, 8'($urandom % 3), 1'($urandom % 4 == 0), 1'($urandom % 8 != 0)),
                {$urandom} & 32'hFFFF_FF3C | 32'(($urandom % 6 == 0) ? 2 : 0));
      else
        doLookup("RND R2/R3/R4/R6/R7/R8/R9", va, 8'($urandom % 3), 1'($urandom % 2),
                 1'($urandom % 2), 2'($urandom));
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule